// File: doc/BRIEF.md
# Burst Memory Host with Shared Stall Line

This block is the host-side sequencer for a synchronous-burst pseudo-SRAM. The memory sits on a bus where several devices drive one wired-OR stall line, and a pull network holds that line low when nobody drives it. A client hands the block a request with a start address, a beat count, a direction and an asynchronous-write flag. The block then drives chip enable, the address-valid strobe, write enable and the memory clock enable. It watches the shared stall line to find out on which clock edges read data is valid or write data is taken.

Read beats come back as a data word with a one-cycle valid pulse. Write beats pull one word from the client through a take strobe, and only on edges the memory accepts. A configuration input chooses between two alignments of the stall line. In one, data moves on the first edge where the line is low. In the other, each stall ends one cycle after the line drops. Asynchronous writes run with the memory clock held still, and the stall line is not consulted during them. A watchdog ends a burst that has stalled for too long. After a burst, chip enable is released for a clock. After an asynchronous write, chip enable can stay low so that a following request starts at once.

Top module: `burst_wait_host`

## Requirements
- R1: Out of reset, mem_ce_n is 1, req_ready is 1, mem_clk_en is 0, and rd_valid and err_timeout are 0. req_ready is 1 only while the block is idle, or in the one-cycle hold slot that follows an asynchronous write.
- R2: An accepted synchronous request (req_async=0, or any read) first spends one cycle with mem_ce_n=0, mem_adv_n=0 and mem_clk_en=1. The burst cycles follow, with mem_clk_en=1. A req_len of 0 runs one beat.
- R3: With cfg_wait_early=1, every burst cycle in which mem_wait (active high) is 0 is a beat.
- R4: With cfg_wait_early=0, a burst cycle is a beat only if mem_wait is 0 in that cycle and was also 0 in the previous burst cycle. The cycle before the first burst cycle counts as 0.
- R5: mem_ce_n stays 0 through every burst cycle, stalled or not.
- R6: A read beat produces rd_valid=1 for exactly one cycle, in the cycle after the beat. rd_data then holds the mem_dq_in value sampled in the beat.
- R7: A write beat raises wr_take in the same cycle. A burst takes exactly req_len words (1 for 0).
- R8: If 64 consecutive burst cycles are stalls, the burst ends at the 64th stall. err_timeout pulses for one cycle in the next cycle, with mem_ce_n=1.
- R9: An asynchronous write (req_write=1, req_async=1) holds mem_clk_en=0 and mem_we_n=0. It spends ASYNC_CYC (3) cycles per word, pulses wr_take on the last cycle of each word and increments mem_addr after it. mem_wait has no effect on it.
- R10: After a synchronous burst ends, the block spends one cycle with mem_ce_n=1 and req_ready=0 before it returns to idle.
- R11: With fixed latency enabled (default), an asynchronous write ends in a hold cycle with mem_ce_n=0 and req_ready=1. A request accepted there starts with chip enable kept low. Without a request, the block goes idle.
- R12: In an asynchronous write, mem_adv_n is 0 in the first cycle of each word and 1 in the rest of the word (default ADV_HOLD=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wait_early | input | 1 | 1: beat on first low stall edge; 0: one cycle later |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 write, 0 read |
| req_async | input | 1 | Asynchronous write when set with req_write |
| req_addr | input | AW | Start address |
| req_len | input | LENW | Beat count (0 means 1) |
| wr_data | input | DW | Current write word |
| wr_take | output | 1 | Write word consumed this cycle |
| rd_data | output | DW | Read word |
| rd_valid | output | 1 | Read word valid pulse |
| err_timeout | output | 1 | Stall watchdog abort pulse |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_clk_en | output | 1 | Memory clock running |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | DW | Write data to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DW | Read data from memory |
| mem_wait | input | 1 | Shared wired-OR stall line, active high |

## Verification
The hardest case to reach is the late alignment mode. In that mode a beat depends on the stall line in two consecutive burst cycles, and that line is the OR of this memory and other devices. The bench builds the line from two independent periodic sources, so isolated one-cycle stalls and back-to-back stalls both show up during read and write bursts. The watchdog needs the stall held for 64 cycles, and the hold-slot handover needs a read request already waiting while an asynchronous write finishes. The bench sets up both on purpose.

// File: rtl/bwh_pkg.sv
package bwh_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_BURST, ST_AWR, ST_HOLD, ST_GAP
  } bwh_state_e;

  // Edge acceptance rule for the shared stall line.
  function automatic logic edge_moves(logic stall_now, logic stall_prev, logic early);
    return !stall_now && (early || !stall_prev);
  endfunction

  // A zero length request runs a single beat.
  function automatic int unsigned beats_of(int unsigned len);
    return (len == 0) ? 1 : len;
  endfunction
endpackage

// File: rtl/bwh_wait_interp.sv
module bwh_wait_interp
  import bwh_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_burst,
  input  logic early,
  input  logic mem_wait,
  output logic beat,
  output logic stall
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= in_burst ? mem_wait : 1'b0;
  end

  assign beat  = in_burst && edge_moves(mem_wait, prev_q, early);
  assign stall = in_burst && !beat;
endmodule

// File: rtl/bwh_stall_wd.sv
module bwh_stall_wd #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic stall,
  output logic abort
);
  localparam int CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (stall) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  assign abort = stall && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/bwh_rd_capture.sv
module bwh_rd_capture #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_beat,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_beat;
      if (rd_beat) rd_data <= dq_in;
    end
  end
endmodule

// File: rtl/burst_wait_host.sv
module burst_wait_host
  import bwh_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 16,
  parameter int LENW      = 6,
  parameter int WD_LIMIT  = 64,
  parameter int ASYNC_CYC = 3,
  parameter bit FIXED_LAT = 1'b1,
  parameter bit ADV_HOLD  = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wait_early,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic            req_async,
  input  logic [AW-1:0]   req_addr,
  input  logic [LENW-1:0] req_len,
  input  logic [DW-1:0]   wr_data,
  output logic            wr_take,
  output logic [DW-1:0]   rd_data,
  output logic            rd_valid,
  output logic            err_timeout,
  output logic            mem_ce_n,
  output logic            mem_adv_n,
  output logic            mem_we_n,
  output logic            mem_clk_en,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_dq_out,
  output logic            mem_dq_oe,
  input  logic [DW-1:0]   mem_dq_in,
  input  logic            mem_wait
);
  localparam int ACW = (ASYNC_CYC > 1) ? $clog2(ASYNC_CYC) : 1;

  bwh_state_e      state_q;
  logic [AW-1:0]   addr_q;
  logic [LENW-1:0] left_q;
  logic [ACW-1:0]  awc_q;
  logic            wr_q;
  logic            err_q;

  // Named events for the checker.
  logic in_burst, in_async, in_hold, accept;
  logic beat, stall, rd_beat, wr_beat, wd_abort, aw_last, last_beat, burst_done;

  assign in_burst   = (state_q == ST_BURST);
  assign in_async   = (state_q == ST_AWR);
  assign in_hold    = (state_q == ST_HOLD);
  assign req_ready  = (state_q == ST_IDLE) || in_hold;
  assign accept     = req_valid && req_ready;

  bwh_wait_interp u_interp (
    .clk(clk), .rst_n(rst_n), .in_burst(in_burst), .early(cfg_wait_early),
    .mem_wait(mem_wait), .beat(beat), .stall(stall)
  );

  bwh_stall_wd #(.LIMIT(WD_LIMIT)) u_wd (
    .clk(clk), .rst_n(rst_n), .stall(stall), .abort(wd_abort)
  );

  assign rd_beat    = beat && !wr_q;
  assign wr_beat    = beat && wr_q;
  assign aw_last    = in_async && (awc_q == ACW'(ASYNC_CYC - 1));
  assign last_beat  = beat && (left_q == LENW'(1));
  assign burst_done = in_burst && (wd_abort || last_beat);

  bwh_rd_capture #(.DW(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .rd_beat(rd_beat), .dq_in(mem_dq_in),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
      awc_q   <= '0;
      wr_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= wd_abort;
      unique case (state_q)
        ST_IDLE, ST_HOLD: begin
          if (accept) begin
            addr_q <= req_addr;
            left_q <= LENW'(beats_of(int'(req_len)));
            wr_q   <= req_write;
            awc_q  <= '0;
            state_q <= (req_write && req_async) ? ST_AWR : ST_ADDR;
          end else if (in_hold) begin
            state_q <= ST_IDLE;
          end
        end
        ST_ADDR: state_q <= ST_BURST;
        ST_BURST: begin
          if (burst_done)  state_q <= ST_GAP;
          else if (beat)   left_q  <= left_q - 1'b1;
        end
        ST_AWR: begin
          if (aw_last) begin
            awc_q  <= '0;
            addr_q <= addr_q + 1'b1;
            if (left_q == LENW'(1)) state_q <= FIXED_LAT ? ST_HOLD : ST_GAP;
            else                    left_q  <= left_q - 1'b1;
          end else begin
            awc_q <= awc_q + 1'b1;
          end
        end
        ST_GAP:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign err_timeout = err_q;
  assign wr_take     = wr_beat || aw_last;
  assign mem_ce_n    = !((state_q == ST_ADDR) || in_burst || in_async || in_hold);
  assign mem_clk_en  = (state_q == ST_ADDR) || in_burst;
  assign mem_adv_n   = !((state_q == ST_ADDR) ||
                         (in_async && (ADV_HOLD || (awc_q == '0))));
  assign mem_we_n    = !(wr_q && ((state_q == ST_ADDR) || in_burst || in_async));
  assign mem_dq_oe   = wr_q && (in_burst || in_async);
  assign mem_dq_out  = wr_data;
  assign mem_addr    = addr_q;
endmodule

// File: rtl/bwh_checker.sv
module bwh_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_wait_early,
  input logic mem_wait,
  input logic mem_ce_n,
  input logic mem_clk_en,
  input logic req_ready,
  input logic rd_valid,
  input logic err_timeout,
  input logic wr_take,
  input logic in_burst,
  input logic in_async,
  input logic beat,
  input logic rd_beat,
  input logic wd_abort,
  input logic burst_done
);
  // R3
  a_r3_beat_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> !mem_wait);
  // R4
  a_r4_late_two_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wait_early && beat && $past(in_burst)) |-> !$past(mem_wait));
  // R5
  a_r5_ce_through_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst && !beat && !wd_abort) |=> !mem_ce_n);
  // R6
  a_r6_valid_after_beat: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |=> rd_valid);
  a_r6_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_beat |=> !rd_valid);
  // R7
  a_r7_take_on_accepted_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_take && mem_clk_en) |-> !mem_wait);
  // R8
  a_r8_abort_reports: assert property (@(posedge clk) disable iff (!rst_n)
    wd_abort |=> (err_timeout && mem_ce_n && !req_ready));
  // R9
  a_r9_async_clock_still: assert property (@(posedge clk) disable iff (!rst_n)
    in_async |-> (!mem_clk_en && !mem_ce_n));
  // R10
  a_r10_release_gap: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> (mem_ce_n && !req_ready));
endmodule

bind burst_wait_host bwh_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wait_early(cfg_wait_early), .mem_wait(mem_wait),
  .mem_ce_n(mem_ce_n), .mem_clk_en(mem_clk_en), .req_ready(req_ready),
  .rd_valid(rd_valid), .err_timeout(err_timeout), .wr_take(wr_take),
  .in_burst(in_burst), .in_async(in_async), .beat(beat), .rd_beat(rd_beat),
  .wd_abort(wd_abort), .burst_done(burst_done)
);

// File: tb/burst_wait_host_tb.sv
module burst_wait_host_tb;
  localparam int WD = 64;
  localparam int AC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wait_early = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0, req_async = 1'b0;
  logic [15:0] req_addr = '0;
  logic [5:0]  req_len = '0;
  logic [15:0] wr_data = '0, mem_dq_in = '0;
  logic mem_wait = 1'b0;
  logic req_ready, wr_take, rd_valid, err_timeout;
  logic mem_ce_n, mem_adv_n, mem_we_n, mem_clk_en, mem_dq_oe;
  logic [15:0] rd_data, mem_addr, mem_dq_out;

  int total = 0, bad = 0;
  int cyc = 0;
  int dev_mode = 0;
  bit other_on = 1'b0;
  int n_rd = 0, n_take = 0, n_err = 0, n_ce_hi = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_wait_host u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wait_early(cfg_wait_early),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_async(req_async), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .err_timeout(err_timeout), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n),
    .mem_we_n(mem_we_n), .mem_clk_en(mem_clk_en), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in),
    .mem_wait(mem_wait)
  );

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Shared stall line: this memory plus another device, pulled low when idle.
  always @(negedge clk) begin
    #1;
    cyc++;
    mem_dq_in = 16'h5A00 ^ 16'(cyc * 7);
    wr_data   = 16'(cyc);
    mem_wait  = ((dev_mode == 2) || (dev_mode == 1 && ((cyc % 5) == 1 || (cyc % 5) == 2)))
              || (other_on && (cyc % 7) == 3);
  end

  // Behavioural reference model, compared every cycle.
  int ph = 0, left = 0, awc = 0, stl = 0;
  bit m_wr = 0, wprev = 0, m_rdv = 0, m_err = 0;
  logic [15:0] m_rdat = '0, m_addr = '0;

  always begin
    @(negedge clk);
    #3;
    if (!rst_n) begin
      ph = 0; left = 0; awc = 0; stl = 0; m_wr = 0; wprev = 0;
      m_rdv = 0; m_err = 0; m_rdat = '0; m_addr = '0;
    end else begin
      bit bt, ab, e_take, e_adv, e_we;
      bt = (ph == 2) && !mem_wait && (cfg_wait_early || !wprev);
      ab = (ph == 2) && !bt && (stl == WD - 1);
      e_take = (bt && m_wr) || (ph == 3 && awc == AC - 1);
      e_adv  = (ph == 1) || (ph == 3 && awc == 0);
      e_we   = m_wr && (ph == 1 || ph == 2 || ph == 3);
      chk(req_ready == (ph == 0 || ph == 4), "R1 ready", req_ready, (ph == 0 || ph == 4));
      chk(mem_ce_n == !(ph >= 1 && ph <= 4), "R5 R10 R11 chip enable", mem_ce_n, !(ph >= 1 && ph <= 4));
      chk(mem_clk_en == (ph == 1 || ph == 2), "R2 R9 clock enable", mem_clk_en, (ph == 1 || ph == 2));
      chk(wr_take == e_take, "R3 R4 R7 R9 write take", wr_take, e_take);
      chk(rd_valid == m_rdv, "R3 R4 R6 read valid", rd_valid, m_rdv);
      if (m_rdv) chk(rd_data == m_rdat, "R6 read data", rd_data, m_rdat);
      chk(err_timeout == m_err, "R8 error pulse", err_timeout, m_err);
      chk(mem_adv_n == !e_adv, "R2 R12 address strobe", mem_adv_n, !e_adv);
      chk(mem_we_n == !e_we, "R9 write enable", mem_we_n, !e_we);
      if (ph != 0) chk(mem_addr == m_addr, "R9 address", mem_addr, m_addr);
      if (rd_valid) n_rd++;
      if (wr_take) n_take++;
      if (err_timeout) n_err++;
      if (mem_ce_n) n_ce_hi++;
      // advance
      m_rdv = bt && !m_wr;
      if (bt && !m_wr) m_rdat = mem_dq_in;
      m_err = ab;
      stl = (ph == 2 && !bt) ? stl + 1 : 0;
      wprev = (ph == 2) ? mem_wait : 1'b0;
      case (ph)
        0, 4: begin
          if (req_valid) begin
            m_addr = req_addr;
            left = (req_len == 0) ? 1 : int'(req_len);
            m_wr = req_write;
            awc = 0;
            ph = (req_write && req_async) ? 3 : 1;
          end else ph = 0;
        end
        1: ph = 2;
        2: begin
          if (ab || (bt && left == 1)) ph = 5;
          else if (bt) left--;
        end
        3: begin
          if (awc == AC - 1) begin
            awc = 0; m_addr = m_addr + 1;
            if (left == 1) ph = 4; else left--;
          end else awc++;
        end
        default: ph = 0;
      endcase
    end
  end

  task automatic issue(bit w, bit a, logic [15:0] ad, logic [5:0] ln);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_async = a; req_addr = ad; req_len = ln;
    #2;
    while (!req_ready) begin @(negedge clk); #2; end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic to_idle();
    @(negedge clk); #2;
    while (!(req_ready && mem_ce_n)) begin @(negedge clk); #2; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #2;
    chk(mem_ce_n == 1 && req_ready == 1 && mem_clk_en == 0, "R1 reset outputs", {mem_ce_n, req_ready, mem_clk_en}, 3'b110);
    chk(rd_valid == 0 && err_timeout == 0, "R1 reset flags", {rd_valid, err_timeout}, 0);
    @(negedge clk); rst_n = 1'b1;

    // R3: early alignment, periodic stalls, read
    cfg_wait_early = 1; dev_mode = 1; n_rd = 0;
    issue(0, 0, 16'h0100, 6'd5); to_idle();
    chk(n_rd == 5, "R3 early read beats", n_rd, 5);

    // R4: late alignment with shared line from another device
    cfg_wait_early = 0; other_on = 1; n_rd = 0;
    issue(0, 0, 16'h0200, 6'd6); to_idle();
    chk(n_rd == 6, "R4 late read beats", n_rd, 6);

    // R7: writes in both alignments
    cfg_wait_early = 1; n_take = 0;
    issue(1, 0, 16'h0300, 6'd4); to_idle();
    chk(n_take == 4, "R7 early write words", n_take, 4);
    cfg_wait_early = 0; n_take = 0;
    issue(1, 0, 16'h0310, 6'd3); to_idle();
    chk(n_take == 3, "R7 late write words", n_take, 3);

    // R2: zero length runs one beat
    cfg_wait_early = 1; other_on = 0; dev_mode = 0; n_rd = 0;
    issue(0, 0, 16'h0400, 6'd0); to_idle();
    chk(n_rd == 1, "R2 zero length beat", n_rd, 1);

    // R9 R11: async write with stall held high, then read handed over in hold slot
    dev_mode = 2; n_take = 0; n_rd = 0;
    issue(1, 1, 16'h0500, 6'd3);
    dev_mode = 0;
    n_ce_hi = 0;
    issue(0, 0, 16'h0600, 6'd2);
    chk(n_ce_hi == 0, "R11 chip enable kept low", n_ce_hi, 0);
    to_idle();
    chk(n_take == 3, "R9 async words", n_take, 3);
    chk(n_rd == 2, "R11 read after hold", n_rd, 2);

    // R8: watchdog
    dev_mode = 2; n_rd = 0; n_err = 0;
    issue(0, 0, 16'h0700, 6'd4); to_idle();
    chk(n_err == 1, "R8 watchdog error", n_err, 1);
    chk(n_rd == 0, "R8 no data on abort", n_rd, 0);
    dev_mode = 0;

    // R10: back-to-back requests see a release cycle
    n_rd = 0;
    issue(0, 0, 16'h0800, 6'd2);
    issue(0, 0, 16'h0900, 6'd2);
    to_idle();
    chk(n_rd == 4, "R10 two bursts", n_rd, 4);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule